// File: doc/BRIEF.md
# Lockable Sensor Configuration Register

This block holds the 16-bit configuration word of a digital temperature sensor and enforces its write-protection rules. A host write presents a full word. Every field is then updated, held or partly refused, depending on two sticky lock bits and the current shutdown state. The block also decides whether the alarm limit registers (high and low) and the critical limit register may take a write in the current cycle. It outputs gated write enables for them.

The block leaves three things to its neighbours: register addressing, the serial bus and the event logic. The event logic supplies a polarity-independent event state. The block reports that state in the read value, and it issues a one-cycle clear strobe when the host writes a 1 to the clear position. A power-on reset (synchronous, active low) is the only way to release a lock.

Top module: `sensor_cfg_reg`

## Requirements
- R1: After reset, every stored field is 0, `cfg_rdata` reads 0x0000 while `evt_state_in` is 0, and `shutdown` is 0 (sensor active).
- R2: Read layout of `cfg_rdata`: bits 15:11 always read 0 and bit 5 (clear) always reads 0. Bit 4 follows `evt_state_in` directly. The stored fields take bits 10:9 hysteresis, 8 shutdown, 7 critical lock, 6 alarm lock, 3 event enable, 2 critical-only, 1 polarity and 0 mode.
- R3: With both locks clear before a write, every stored field takes the written value at the next clock edge, using the bit positions of R2. Writes to bits 15:11 and bit 4 have no effect.
- R4: A lock bit that is 1 stays 1 through any write, including a write of 0. Only reset clears it.
- R5: While either lock was 1 before a write, the hysteresis, event enable, polarity and mode fields keep their values.
- R6: While either lock was 1 before a write, shutdown cannot go from 0 to 1, but a write of 0 clears it.
- R7: While the alarm lock was 1 before a write, critical-only cannot go from 0 to 1, but it can be cleared. The critical lock alone does not restrict critical-only.
- R8: `alarm_lim_we` equals `alarm_lim_req` when the alarm lock is 0 and is all zero when it is 1. `crit_lim_we` equals `crit_lim_req` gated in the same way by the critical lock.
- R9: A write with bit 5 set raises `clear_pulse` for exactly the one cycle after the write edge. This happens whatever the lock state is, and the write changes no stored field through bit 5.
- R10: Each field is gated on its own against the state before the write. In one write, allowed fields update and blocked fields hold. A write that sets a lock also updates the fields it would protect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Host write strobe for the configuration word |
| wr_data | input | 16 | Host write data |
| evt_state_in | input | 1 | Polarity-independent event state from the event logic |
| alarm_lim_req | input | 2 | Write requests for the alarm limit registers (bit 1 high, bit 0 low) |
| crit_lim_req | input | 1 | Write request for the critical limit register |
| cfg_rdata | output | 16 | Read value of the configuration word |
| hyst_code | output | 2 | Hysteresis select code |
| shutdown | output | 1 | Sensor shut down |
| crit_lock | output | 1 | Critical limit lock |
| alarm_lock | output | 1 | Alarm limit lock |
| evt_enable | output | 1 | Event output enable |
| crit_only | output | 1 | Events from the critical limit only |
| evt_pol | output | 1 | Event polarity, 1 active high |
| evt_mode | output | 1 | Event mode, 1 interrupt, 0 comparator |
| clear_pulse | output | 1 | One-cycle event clear strobe |
| alarm_lim_we | output | 2 | Gated alarm limit write enables |
| crit_lim_we | output | 1 | Gated critical limit write enable |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 2-bit hysteresis code and two alarm limit requests. With these values every field and both limit gates can be reached from the ports. The scenarios cover the alarm lock alone, the critical lock alone and both locks together. That covers the rule differences between the locks: critical-only stays free under the critical lock, and the two limit gates are separate. Several scenarios mix allowed and blocked fields in a single write.

// File: rtl/sensor_cfg_pkg.sv
// Shared types and field positions for the sensor configuration register.
// Assumes a 16-bit host word. Positions are fixed because the event logic
// and the host software decode them.
package sensor_cfg_pkg;
    localparam int REG_W    = 16;
    localparam int HYST_W   = 2;
    localparam int POS_HYST = 9;
    localparam int POS_SD   = 8;
    localparam int POS_CLK  = 7;
    localparam int POS_ALK  = 6;
    localparam int POS_CLR  = 5;
    localparam int POS_STS  = 4;
    localparam int POS_EN   = 3;
    localparam int POS_CO   = 2;
    localparam int POS_POL  = 1;
    localparam int POS_MODE = 0;
    localparam int POS_TOP  = POS_HYST + HYST_W;

    typedef struct packed {
        logic [HYST_W-1:0] hyst;
        logic              sd;
        logic              clk_lock;
        logic              alm_lock;
        logic              en;
        logic              co;
        logic              pol;
        logic              mode;
    } cfg_t;
endpackage

// File: rtl/sensor_cfg_next.sv
// Computes the next configuration state for a host write under the lock
// and shutdown rules. Purely combinational. Assumes cur_cfg holds the
// state before the write. Each field is gated independently.
module sensor_cfg_next
    import sensor_cfg_pkg::*;
(
    input  cfg_t             cur_cfg,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             nxt_cfg
);
    logic any_lock;

    // any lock held before this write freezes the protected fields
    always_comb any_lock = cur_cfg.clk_lock | cur_cfg.alm_lock;

    // per-field gating of the written word
    always_comb begin
        nxt_cfg          = cur_cfg;
        nxt_cfg.clk_lock = cur_cfg.clk_lock | wdata[POS_CLK];
        nxt_cfg.alm_lock = cur_cfg.alm_lock | wdata[POS_ALK];
        if (!any_lock) begin
            nxt_cfg.hyst = wdata[POS_HYST +: HYST_W];
            nxt_cfg.en   = wdata[POS_EN];
            nxt_cfg.pol  = wdata[POS_POL];
            nxt_cfg.mode = wdata[POS_MODE];
            nxt_cfg.sd   = wdata[POS_SD];
        end else begin
            nxt_cfg.sd   = cur_cfg.sd & wdata[POS_SD];
        end
        if (cur_cfg.alm_lock) nxt_cfg.co = cur_cfg.co & wdata[POS_CO];
        else                  nxt_cfg.co = wdata[POS_CO];
    end
endmodule

// File: rtl/sensor_cfg_limit_gate.sv
// Gates limit-register write requests with the lock bits. Combinational.
// Assumes the lock inputs are the registered lock state.
module sensor_cfg_limit_gate #(
    parameter int N_ALARM = 2
) (
    input  logic               alm_lock,
    input  logic               clk_lock,
    input  logic [N_ALARM-1:0] alarm_req,
    input  logic               crit_req,
    output logic [N_ALARM-1:0] alarm_we,
    output logic               crit_we
);
    // one gate per alarm limit register
    for (genvar g = 0; g < N_ALARM; g++) begin : g_alarm
        assign alarm_we[g] = alarm_req[g] & ~alm_lock;
    end

    // critical limit gate
    always_comb crit_we = crit_req & ~clk_lock;
endmodule

// File: rtl/sensor_cfg_clear_strobe.sv
// Registers a one-cycle clear strobe from a host write that carries the
// clear bit. Assumes a synchronous active-low reset.
module sensor_cfg_clear_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic clr_bit,
    output logic pulse
);
    // pulse for the cycle after a write with the clear bit set
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= wr_en & clr_bit;
    end
endmodule

// File: rtl/sensor_cfg_reg.sv
// Lockable configuration register of a temperature sensor. Stores the
// configuration fields, applies lock and shutdown rules on writes, gates
// limit-register writes and issues the event clear strobe. Assumes rst_n
// is the power-on reset, the only way to release a lock.
module sensor_cfg_reg
    import sensor_cfg_pkg::*;
#(
    parameter int N_ALARM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               evt_state_in,
    input  logic [N_ALARM-1:0] alarm_lim_req,
    input  logic               crit_lim_req,
    output logic [REG_W-1:0]   cfg_rdata,
    output logic [HYST_W-1:0]  hyst_code,
    output logic               shutdown,
    output logic               crit_lock,
    output logic               alarm_lock,
    output logic               evt_enable,
    output logic               crit_only,
    output logic               evt_pol,
    output logic               evt_mode,
    output logic               clear_pulse,
    output logic [N_ALARM-1:0] alarm_lim_we,
    output logic               crit_lim_we
);
    localparam int RSV_W = REG_W - POS_TOP;

    cfg_t cfg_q;
    cfg_t cfg_d;

    sensor_cfg_next u_next (
        .cur_cfg (cfg_q),
        .wdata   (wr_data),
        .nxt_cfg (cfg_d)
    );

    // configuration state register
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= cfg_d;
    end

    sensor_cfg_clear_strobe u_clr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .clr_bit (wr_data[POS_CLR]),
        .pulse   (clear_pulse)
    );

    sensor_cfg_limit_gate #(.N_ALARM(N_ALARM)) u_lim (
        .alm_lock  (cfg_q.alm_lock),
        .clk_lock  (cfg_q.clk_lock),
        .alarm_req (alarm_lim_req),
        .crit_req  (crit_lim_req),
        .alarm_we  (alarm_lim_we),
        .crit_we   (crit_lim_we)
    );

    // field outputs
    always_comb begin
        hyst_code  = cfg_q.hyst;
        shutdown   = cfg_q.sd;
        crit_lock  = cfg_q.clk_lock;
        alarm_lock = cfg_q.alm_lock;
        evt_enable = cfg_q.en;
        crit_only  = cfg_q.co;
        evt_pol    = cfg_q.pol;
        evt_mode   = cfg_q.mode;
    end

    // read word assembly
    always_comb begin
        cfg_rdata = {{RSV_W{1'b0}}, cfg_q.hyst, cfg_q.sd, cfg_q.clk_lock,
                     cfg_q.alm_lock, 1'b0, evt_state_in, cfg_q.en,
                     cfg_q.co, cfg_q.pol, cfg_q.mode};
    end

    // R4: locks are sticky between resets
    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(crit_lock)) |-> crit_lock)
        else $error("critical lock released without reset");
    p_alock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alarm_lock)) |-> alarm_lock)
        else $error("alarm lock released without reset");

    // R5: protected fields frozen under any lock
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(crit_lock | alarm_lock)) |->
        ($stable(hyst_code) && $stable(evt_enable) && $stable(evt_pol) && $stable(evt_mode)))
        else $error("protected field changed under lock");

    // R6: no shutdown entry under lock
    p_no_sd_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(crit_lock | alarm_lock) && !$past(shutdown)) |-> !shutdown)
        else $error("shutdown entered under lock");

    // R7: critical-only cannot be set under alarm lock
    p_co_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(alarm_lock) && !$past(crit_only)) |-> !crit_only)
        else $error("critical-only set under alarm lock");

    // R8: no limit write enable passes a held lock
    p_lim_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_lock |-> alarm_lim_we == '0) and (crit_lock |-> !crit_lim_we))
        else $error("limit write passed a lock");

    // R9: clear strobe only follows a write carrying the clear bit
    p_clr_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |-> ($past(rst_n) && $past(wr_en) && $past(wr_data[POS_CLR])))
        else $error("clear strobe without clear write");
endmodule

// File: tb/sensor_cfg_reg_test.sv
// Directed bench for sensor_cfg_reg: one task per scenario.
module sensor_cfg_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        evt_state_in = 1'b0;
    logic [1:0]  alarm_lim_req = 2'b11;
    logic        crit_lim_req = 1'b1;
    logic [15:0] cfg_rdata;
    logic [1:0]  hyst_code;
    logic        shutdown, crit_lock, alarm_lock, evt_enable, crit_only;
    logic        evt_pol, evt_mode, clear_pulse, crit_lim_we;
    logic [1:0]  alarm_lim_we;
    int          n_checks = 0;
    int          n_errors = 0;

    sensor_cfg_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .evt_state_in(evt_state_in), .alarm_lim_req(alarm_lim_req),
        .crit_lim_req(crit_lim_req), .cfg_rdata(cfg_rdata),
        .hyst_code(hyst_code), .shutdown(shutdown), .crit_lock(crit_lock),
        .alarm_lock(alarm_lock), .evt_enable(evt_enable), .crit_only(crit_only),
        .evt_pol(evt_pol), .evt_mode(evt_mode), .clear_pulse(clear_pulse),
        .alarm_lim_we(alarm_lim_we), .crit_lim_we(crit_lim_we)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // write one word; returns sampled clear_pulse of the following cycle
    task automatic wr(input logic [15:0] d, output logic pulse);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) begin wr_en = 1'b0; wr_data = '0; pulse = clear_pulse; end
    endtask

    task automatic t_reset();
        logic p;
        do_reset();
        chk("R1 reset word", cfg_rdata, 16'h0000);
        chk("R1 shutdown", {15'd0, shutdown}, 16'd0);
        chk("R8 alarm we unlocked", {14'd0, alarm_lim_we}, 16'd3);
        chk("R8 crit we unlocked", {15'd0, crit_lim_we}, 16'd1);
        evt_state_in = 1'b1; #1;
        chk("R2 status follows input", cfg_rdata, 16'h0010);
        evt_state_in = 1'b0;
        wr(16'h0000, p);
        chk("R9 no pulse without clear bit", {15'd0, p}, 16'd0);
    endtask

    task automatic t_unlocked();
        logic p;
        do_reset();
        wr(16'hFF3F, p);
        chk("R3 R2 full write", cfg_rdata, 16'h070F);
        chk("R3 hyst field", {14'd0, hyst_code}, 16'd3);
        chk("R9 clear pulse high", {15'd0, p}, 16'd1);
        @(negedge clk);
        chk("R9 clear pulse one cycle", {15'd0, clear_pulse}, 16'd0);
        wr(16'h0000, p);
        chk("R3 write zero", cfg_rdata, 16'h0000);
        wr(16'h0402, p);
        chk("R3 partial pattern", cfg_rdata, 16'h0402);
    endtask

    task automatic t_alarm_lock();
        logic p;
        do_reset();
        wr(16'h064B, p);
        chk("R10 lock and fields same write", cfg_rdata, 16'h064B);
        wr(16'h0104, p);
        chk("R4 R5 R6 R7 blocked write", cfg_rdata, 16'h064B);
        chk("R8 alarm we blocked", {14'd0, alarm_lim_we}, 16'd0);
        chk("R8 crit we open", {15'd0, crit_lim_we}, 16'd1);
        wr(16'h0020, p);
        chk("R9 pulse under lock", {15'd0, p}, 16'd1);
        chk("R9 clear keeps state", cfg_rdata, 16'h064B);
    endtask

    task automatic t_crit_lock();
        logic p;
        do_reset();
        wr(16'h0104, p);
        chk("R3 shutdown and crit-only set", cfg_rdata, 16'h0104);
        wr(16'h0184, p);
        chk("R10 crit lock set", cfg_rdata, 16'h0184);
        wr(16'h0000, p);
        chk("R6 R7 clear allowed, R4 lock held", cfg_rdata, 16'h0080);
        wr(16'h0004, p);
        chk("R7 crit-only free under crit lock", cfg_rdata, 16'h0084);
        wr(16'h0109, p);
        chk("R5 R6 R10 mixed write", cfg_rdata, 16'h0080);
        chk("R8 crit we blocked", {15'd0, crit_lim_we}, 16'd0);
        chk("R8 alarm we open", {14'd0, alarm_lim_we}, 16'd3);
    endtask

    task automatic t_both_and_reset();
        logic p;
        do_reset();
        wr(16'h00C0, p);
        wr(16'h0000, p);
        chk("R4 both locks sticky", cfg_rdata, 16'h00C0);
        do_reset();
        chk("R1 R4 reset releases locks", cfg_rdata, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_unlocked();
        t_alarm_lock();
        t_crit_lock();
        t_both_and_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #80000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule